// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block chooses the next 13-bit program counter value of a small 4-bit processor core and keeps the return stack that calls and interrupts use. Each cycle in which `op_valid` is high, the decoder presents one operation code, the instruction length in bytes, the status condition `sf`, an address field, and the side values the operation needs: a short-call index, an interrupt source, the flags to save, or a new stack level. On the next rising edge the block updates `pc`, and also `sp`, the restored flags and the interrupt-enable bit where the operation calls for it. Instruction fetch and decode are outside the block.

Branches write only part of the counter. A short branch replaces the low six bits of the incremented counter. A long branch keeps the top bit of the current counter. An extra-long branch takes its top bit from the decoder. Short calls go to fixed vectors computed from a 4-bit index, and interrupts go to fixed even vectors near address zero. The stack grows downward: level `DEPTH` means empty and level 0 means full. Software can move the stack level.

A two-state machine watches the stack. `ST_RUN` is the state after reset. The transition RUN→FAULT fires when a push reaches a full stack or a pop reaches an empty one. `ST_FAULT` holds until reset, and the FAULT→FAULT self-loop keeps the error output set while sequencing goes on normally. There is no transition from FAULT back to RUN except reset.

Top module: `pcseq_top`

## Requirements
- R1: After reset, `pc`=000h, `sp`=13 (empty), `ie`=0, `flags_out`=0 and `stk_err`=0.
- R2: op=0 (step) advances `pc` by `ilen` (1, 2 or 3), modulo 2^13. When `op_valid` is low, `pc`, `sp`, `ie` and `flags_out` hold their values.
- R3: op=1 (short branch) with `sf`=1 loads bits 12..6 of (pc+1) followed by `tgt[5:0]`. This crosses into the next 64-byte page when pc+1 does.
- R4: op=2 (long branch) with `sf`=1 keeps bit 12 of the current `pc` and loads `tgt[11:0]` into bits 11..0.
- R5: op=3 (extra-long branch) with `sf`=1 loads `{xbr_hi, tgt[11:0]}`. `xbr_hi` selects the upper or lower 4K half.
- R6: ops 1, 2 and 3 with `sf`=0 advance `pc` by `ilen`.
- R7: op=4 (short call) with index n jumps to 8n+6 for n=1..15 and to 086h for n=0. It decrements `sp` and then stores `pc+ilen` at the new level.
- R8: op=5 (long call) jumps to `{2'b00, tgt[10:0]}`, which is in the range 0000h–07FFh. It pushes `pc+ilen` the same way as R7.
- R9: op=6 (interrupt) with `irq_src` 0..5 jumps to 002h, 004h, 006h, 008h, 00Ah or 00Ch respectively. It pushes the current `pc` together with `flags_in` and clears `ie`. Sources 6 and 7 change nothing.
- R10: op=7 (return) loads `pc` from the level `sp` points to and then increments `sp`. It leaves `flags_out` and `ie` unchanged.
- R11: op=8 (return from interrupt) does what R10 does. It also loads `flags_out` from the saved entry and sets `ie`.
- R12: op=9 (set level) loads `sp_val` into `sp` when `sp_val` ≤ 13. Larger values are ignored.
- R13: A push when `sp`=0 or a pop when `sp`=13 sets `stk_err`. The stack and `sp` stay unchanged. A failed push still jumps to its target, and a failed pop advances `pc` by `ilen`. `stk_err` stays set until reset.
- R14: Thirteen nested calls fill every level. Returns then come back in reverse order to each call's return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (0 step, 1 short branch, 2 long branch, 3 extra-long branch, 4 short call, 5 long call, 6 interrupt, 7 return, 8 return from interrupt, 9 set level) |
| ilen | input | 2 | Instruction length in bytes (1..3) |
| sf | input | 1 | Branch condition |
| tgt | input | PC_W | Address field of the instruction |
| xbr_hi | input | 1 | Upper target bit of an extra-long branch |
| sc_idx | input | 4 | Short-call index n |
| irq_src | input | 3 | Interrupt source number |
| flags_in | input | 3 | Flags saved on interrupt entry |
| sp_val | input | clog2(DEPTH+1) | New stack level for op 9 |
| pc | output | PC_W | Program counter |
| sp | output | clog2(DEPTH+1) | Stack level |
| flags_out | output | 3 | Flags restored by return from interrupt |
| ie | output | 1 | Interrupt enable |
| stk_err | output | 1 | Sticky stack overflow or underflow |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, 13 stack levels and six interrupt sources. With these values a short branch can be placed at 0FFFh so that the page carry into bit 6 is seen, and both halves of the extra-long branch are reachable. The stack is shallow enough to fill completely and drain completely within one run. That makes the overflow and underflow paths of the fault state machine reachable, along with the reverse ordering of thirteen nested returns.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int FLAG_W = 3;

    typedef enum logic [3:0] {
        OP_STEP  = 4'd0,
        OP_SBR   = 4'd1,
        OP_LBR   = 4'd2,
        OP_XBR   = 4'd3,
        OP_SCALL = 4'd4,
        OP_LCALL = 4'd5,
        OP_IRQ   = 4'd6,
        OP_RET   = 4'd7,
        OP_RETI  = 4'd8,
        OP_SETSP = 4'd9
    } op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } st_e;

    // vector used by the short call whose index is zero
    localparam logic [7:0] SCALL_ZERO_VEC = 8'h86;

endpackage

// File: rtl/pcseq_target.sv
// Combinational target generation for every flow-change kind.
module pcseq_target #(
    parameter int PC_W  = 13,
    parameter int IRQ_N = 6
) (
    input  logic [PC_W-1:0] pc,
    input  logic [1:0]      ilen,
    input  logic [PC_W-1:0] tgt,
    input  logic            xbr_hi,
    input  logic [3:0]      sc_idx,
    input  logic [2:0]      irq_src,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] sbr_pc,
    output logic [PC_W-1:0] lbr_pc,
    output logic [PC_W-1:0] xbr_pc,
    output logic [PC_W-1:0] scall_pc,
    output logic [PC_W-1:0] lcall_pc,
    output logic [PC_W-1:0] irq_pc,
    output logic            irq_ok
);
    import pcseq_pkg::*;

    localparam int SBR_W   = 6;
    localparam int LBR_W   = PC_W - 1;
    localparam int LCALL_W = PC_W - 2;
    localparam logic [2:0] IRQ_LIM = 3'(IRQ_N);

    logic [PC_W-1:0] pc_inc1;
    logic [7:0]      sc_vec;
    logic [3:0]      irq_vec;

    always_comb begin
        pc_inc1  = pc + PC_W'(1);
        seq_pc   = pc + PC_W'(ilen);
        sbr_pc   = {pc_inc1[PC_W-1:SBR_W], tgt[SBR_W-1:0]};
        lbr_pc   = {pc[PC_W-1], tgt[LBR_W-1:0]};
        xbr_pc   = {xbr_hi, tgt[LBR_W-1:0]};
        lcall_pc = {2'b00, tgt[LCALL_W-1:0]};
        sc_vec   = (sc_idx == 4'd0) ? SCALL_ZERO_VEC : {1'b0, sc_idx, 3'b110};
        scall_pc = {{(PC_W-8){1'b0}}, sc_vec};
        irq_vec  = {irq_src + 3'd1, 1'b0};
        irq_pc   = {{(PC_W-4){1'b0}}, irq_vec};
        irq_ok   = (irq_src < IRQ_LIM);
    end

endmodule

// File: rtl/pcseq_stack.sv
// Downward-growing return stack; level DEPTH is empty, level 0 is full.
module pcseq_stack #(
    parameter int DEPTH = 13,
    parameter int ENT_W = 16,
    parameter int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic             ld_en,
    input  logic [SP_W-1:0]  ld_val,
    input  logic [ENT_W-1:0] push_data,
    output logic [SP_W-1:0]  sp,
    output logic [ENT_W-1:0] top_data,
    output logic             full,
    output logic             empty
);
    localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(DEPTH);

    logic [SP_W-1:0]  sp_q;
    logic [ENT_W-1:0] slot_arr [DEPTH];

    assign full  = (sp_q == '0);
    assign empty = (sp_q == SP_EMPTY);
    assign sp    = sp_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_level
        logic [ENT_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (push_en && !full && sp_q == SP_W'(i + 1)) begin
                slot_q <= push_data;
            end
        end
        assign slot_arr[i] = slot_q;
    end

    always_comb begin
        top_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SP_W'(i)) top_data = slot_arr[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_EMPTY;
        end else if (push_en) begin
            if (!full) sp_q <= sp_q - SP_W'(1);
        end else if (pop_en) begin
            if (!empty) sp_q <= sp_q + SP_W'(1);
        end else if (ld_en && ld_val <= SP_EMPTY) begin
            sp_q <= ld_val;
        end
    end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 13,
    parameter int IRQ_N = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_valid,
    input  logic [3:0]                    op,
    input  logic [1:0]                    ilen,
    input  logic                          sf,
    input  logic [PC_W-1:0]               tgt,
    input  logic                          xbr_hi,
    input  logic [3:0]                    sc_idx,
    input  logic [2:0]                    irq_src,
    input  logic [2:0]                    flags_in,
    input  logic [$clog2(DEPTH+1)-1:0]    sp_val,
    output logic [PC_W-1:0]               pc,
    output logic [$clog2(DEPTH+1)-1:0]    sp,
    output logic [2:0]                    flags_out,
    output logic                          ie,
    output logic                          stk_err
);
    import pcseq_pkg::*;

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int ENT_W = FLAG_W + PC_W;

    op_e opc;
    st_e state_q, state_nx;

    logic [PC_W-1:0]   pc_q, pc_nx;
    logic [FLAG_W-1:0] fl_q, fl_nx;
    logic              ie_q, ie_nx;

    logic [PC_W-1:0] seq_pc, sbr_pc, lbr_pc, xbr_pc, scall_pc, lcall_pc, irq_pc;
    logic            irq_ok;

    logic             want_push, want_pop, set_lvl, viol;
    logic [PC_W-1:0]  ret_addr;
    logic [ENT_W-1:0] push_data, top_data;
    logic             full, empty;

    assign opc = op_e'(op);

    pcseq_target #(.PC_W(PC_W), .IRQ_N(IRQ_N)) u_target (
        .pc       (pc_q),
        .ilen     (ilen),
        .tgt      (tgt),
        .xbr_hi   (xbr_hi),
        .sc_idx   (sc_idx),
        .irq_src  (irq_src),
        .seq_pc   (seq_pc),
        .sbr_pc   (sbr_pc),
        .lbr_pc   (lbr_pc),
        .xbr_pc   (xbr_pc),
        .scall_pc (scall_pc),
        .lcall_pc (lcall_pc),
        .irq_pc   (irq_pc),
        .irq_ok   (irq_ok)
    );

    // stack request decode
    always_comb begin
        want_push = op_valid && (opc == OP_SCALL || opc == OP_LCALL ||
                                 (opc == OP_IRQ && irq_ok));
        want_pop  = op_valid && (opc == OP_RET || opc == OP_RETI);
        set_lvl   = op_valid && (opc == OP_SETSP);
        ret_addr  = (opc == OP_IRQ) ? pc_q : seq_pc;
        push_data = {flags_in, ret_addr};
        viol      = (want_push && full) || (want_pop && empty);
    end

    pcseq_stack #(.DEPTH(DEPTH), .ENT_W(ENT_W), .SP_W(SP_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (want_push),
        .pop_en    (want_pop),
        .ld_en     (set_lvl),
        .ld_val    (sp_val),
        .push_data (push_data),
        .sp        (sp),
        .top_data  (top_data),
        .full      (full),
        .empty     (empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN:   if (viol) state_nx = ST_FAULT;
            ST_FAULT: state_nx = ST_FAULT;
            default:  state_nx = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        stk_err   = (state_q == ST_FAULT);
        pc        = pc_q;
        flags_out = fl_q;
        ie        = ie_q;
    end

    // next program counter, flags and enable
    always_comb begin
        pc_nx = pc_q;
        fl_nx = fl_q;
        ie_nx = ie_q;
        if (op_valid) begin
            unique case (opc)
                OP_STEP:  pc_nx = seq_pc;
                OP_SBR:   pc_nx = sf ? sbr_pc : seq_pc;
                OP_LBR:   pc_nx = sf ? lbr_pc : seq_pc;
                OP_XBR:   pc_nx = sf ? xbr_pc : seq_pc;
                OP_SCALL: pc_nx = scall_pc;
                OP_LCALL: pc_nx = lcall_pc;
                OP_IRQ: begin
                    if (irq_ok) begin
                        pc_nx = irq_pc;
                        ie_nx = 1'b0;
                    end
                end
                OP_RET:   pc_nx = empty ? seq_pc : top_data[PC_W-1:0];
                OP_RETI: begin
                    if (empty) begin
                        pc_nx = seq_pc;
                    end else begin
                        pc_nx = top_data[PC_W-1:0];
                        fl_nx = top_data[ENT_W-1:PC_W];
                        ie_nx = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            fl_q <= '0;
            ie_q <= 1'b0;
        end else begin
            pc_q <= pc_nx;
            fl_q <= fl_nx;
            ie_q <= ie_nx;
        end
    end

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 13,
    parameter int IRQ_N = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [3:0]                 op,
    input logic                       sf,
    input logic [PC_W-1:0]            tgt,
    input logic [2:0]                 irq_src,
    input logic [$clog2(DEPTH+1)-1:0] sp_val,
    input logic [PC_W-1:0]            pc,
    input logic [$clog2(DEPTH+1)-1:0] sp,
    input logic                       ie,
    input logic                       stk_err
);
    import pcseq_pkg::*;

    localparam int SP_W = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(DEPTH);
    localparam logic [2:0]      IRQ_LIM  = 3'(IRQ_N);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(pc) && $stable(sp) && $stable(ie)));

    p_sbr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SBR && sf) |=> pc[5:0] == $past(tgt[5:0]));

    p_scall_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SCALL) |=> pc[2:0] == 3'b110);

    p_call_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_SCALL || op == OP_LCALL) && sp != '0)
        |=> sp == $past(sp) - SP_W'(1));

    p_lcall_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_LCALL) |=> pc[PC_W-1:PC_W-2] == 2'b00);

    p_irq_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_IRQ && irq_src < IRQ_LIM)
        |=> (!ie && pc[PC_W-1:4] == '0 && !pc[0]));

    p_ret_sp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_RET || op == OP_RETI) && sp != SP_EMPTY)
        |=> sp == $past(sp) + SP_W'(1));

    p_reti_ie_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_RETI && sp != SP_EMPTY) |=> ie);

    p_setsp_big_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SETSP && sp_val > SP_EMPTY) |=> $stable(sp));

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    p_sp_range_r14: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_EMPTY);

endmodule

bind pcseq_top pcseq_chk #(.PC_W(PC_W), .DEPTH(DEPTH), .IRQ_N(IRQ_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op       (op),
    .sf       (sf),
    .tgt      (tgt),
    .irq_src  (irq_src),
    .sp_val   (sp_val),
    .pc       (pc),
    .sp       (sp),
    .ie       (ie),
    .stk_err  (stk_err)
);

// File: tb/tb_pcseq_top.sv
`timescale 1ns/1ps
module tb_pcseq_top;

    localparam int DEPTH = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  ilen = 2'd1;
    logic        sf = 1'b0;
    logic [12:0] tgt = '0;
    logic        xbr_hi = 1'b0;
    logic [3:0]  sc_idx = '0;
    logic [2:0]  irq_src = '0;
    logic [2:0]  flags_in = '0;
    logic [3:0]  sp_val = '0;
    logic [12:0] pc;
    logic [3:0]  sp;
    logic [2:0]  flags_out;
    logic        ie;
    logic        stk_err;

    always #10 clk = ~clk;

    pcseq_top dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .ilen(ilen),
        .sf(sf), .tgt(tgt), .xbr_hi(xbr_hi), .sc_idx(sc_idx), .irq_src(irq_src),
        .flags_in(flags_in), .sp_val(sp_val), .pc(pc), .sp(sp),
        .flags_out(flags_out), .ie(ie), .stk_err(stk_err)
    );

    typedef struct {
        logic [12:0] pc;
        int          sp;
        logic        ie;
        logic        err;
        logic [2:0]  fl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [12:0] m_pc;
    int          m_sp;
    logic        m_ie, m_err;
    logic [2:0]  m_fl;
    logic [15:0] m_stk [DEPTH];

    task automatic compare(input exp_t e);
        checks++;
        if (pc !== e.pc || int'(sp) != e.sp || ie !== e.ie ||
            stk_err !== e.err || flags_out !== e.fl) begin
            fails++;
            $display("FAIL %s: pc=%h sp=%0d ie=%b err=%b fl=%h expected pc=%h sp=%0d ie=%b err=%b fl=%h",
                     e.tag, pc, sp, ie, stk_err, flags_out,
                     e.pc, e.sp, e.ie, e.err, e.fl);
        end
    endtask

    // monitor: results of an op driven at a falling edge appear after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    function automatic void m_push(input logic [12:0] ra, input logic [2:0] f);
        if (m_sp == 0) m_err = 1'b1;
        else begin
            m_sp = m_sp - 1;
            m_stk[m_sp] = {f, ra};
        end
    endfunction

    task automatic do_op(input logic [3:0] o, input logic [1:0] len, input logic s,
                         input logic [12:0] t, input logic xh, input logic [3:0] n,
                         input logic [2:0] src, input logic [2:0] f,
                         input logic [3:0] spv, input string tag);
        exp_t e;
        logic [12:0] nxt;
        logic [12:0] p1;
        @(negedge clk);
        op_valid = 1'b1; op = o; ilen = len; sf = s; tgt = t; xbr_hi = xh;
        sc_idx = n; irq_src = src; flags_in = f; sp_val = spv;
        nxt = m_pc + 13'(len);
        p1  = m_pc + 13'd1;
        case (o)
            4'd0: m_pc = nxt;
            4'd1: m_pc = s ? {p1[12:6], t[5:0]} : nxt;
            4'd2: m_pc = s ? {m_pc[12], t[11:0]} : nxt;
            4'd3: m_pc = s ? {xh, t[11:0]} : nxt;
            4'd4: begin
                m_push(nxt, f);
                m_pc = (n == 0) ? 13'h086 : 13'(8 * n + 6);
            end
            4'd5: begin
                m_push(nxt, f);
                m_pc = {2'b00, t[10:0]};
            end
            4'd6: if (src < 6) begin
                m_push(m_pc, f);
                m_pc = 13'(2 * (src + 1));
                m_ie = 1'b0;
            end
            4'd7, 4'd8: begin
                if (m_sp == DEPTH) begin
                    m_err = 1'b1;
                    m_pc = nxt;
                end else begin
                    m_pc = m_stk[m_sp][12:0];
                    if (o == 4'd8) begin
                        m_fl = m_stk[m_sp][15:13];
                        m_ie = 1'b1;
                    end
                    m_sp = m_sp + 1;
                end
            end
            4'd9: if (spv <= DEPTH) m_sp = spv;
            default: ;
        endcase
        e.pc = m_pc; e.sp = m_sp; e.ie = m_ie; e.err = m_err; e.fl = m_fl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b0;
        op = 4'd0; tgt = 13'h1FFF; sf = 1'b1;
        e.pc = m_pc; e.sp = m_sp; e.ie = m_ie; e.err = m_err; e.fl = m_fl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        exp_t e;
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_sp = DEPTH; m_ie = 1'b0; m_err = 1'b0; m_fl = '0;
        e.pc = m_pc; e.sp = m_sp; e.ie = m_ie; e.err = m_err; e.fl = m_fl;
        e.tag = "R1 reset state";
        #1 compare(e);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 sequential flow and hold
        do_op(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 step 1");
        do_op(0, 2, 0, 0, 0, 0, 0, 0, 0, "R2 step 2");
        do_op(0, 3, 0, 0, 0, 0, 0, 0, 0, "R2 step 3");
        idle("R2 hold");
        idle("R2 hold again");
        // R4 long branch to page end, R3 short branch across page carry
        do_op(2, 2, 1, 13'h0FFF, 0, 0, 0, 0, 0, "R4 long branch low half");
        do_op(1, 1, 1, 13'h1FD5, 0, 0, 0, 0, 0, "R3 short branch page carry");
        do_op(2, 2, 1, 13'h0ABC, 0, 0, 0, 0, 0, "R4 long branch keeps top bit");
        // R5 extra-long
        do_op(3, 3, 1, 13'h1123, 0, 0, 0, 0, 0, "R5 extra-long lower half");
        do_op(3, 3, 1, 13'h0456, 1, 0, 0, 0, 0, "R5 extra-long upper half");
        // R6 not taken
        do_op(1, 1, 0, 13'h003F, 0, 0, 0, 0, 0, "R6 short not taken");
        do_op(2, 2, 0, 13'h0000, 0, 0, 0, 0, 0, "R6 long not taken");
        do_op(3, 3, 0, 13'h0000, 1, 0, 0, 0, 0, "R6 extra-long not taken");
        // R7 short calls and R10 returns
        do_op(4, 1, 0, 0, 0, 4'd0, 0, 0, 0, "R7 short call n0");
        do_op(4, 1, 0, 0, 0, 4'd1, 0, 0, 0, "R7 short call n1");
        do_op(4, 1, 0, 0, 0, 4'd15, 0, 0, 0, "R7 short call n15");
        do_op(7, 1, 0, 0, 0, 0, 0, 0, 0, "R10 return n15");
        do_op(7, 1, 0, 0, 0, 0, 0, 0, 0, "R10 return n1");
        do_op(7, 1, 0, 0, 0, 0, 0, 0, 0, "R10 return n0");
        // R8 long call
        do_op(5, 2, 0, 13'h1FFF, 0, 0, 0, 0, 0, "R8 long call masked target");
        do_op(7, 1, 0, 0, 0, 0, 0, 0, 0, "R10 return from long call");
        // R9 interrupts with R11 returns
        for (int s = 0; s < 6; s++) begin
            do_op(6, 1, 0, 0, 0, 0, 3'(s), 3'(s + 1), 0, "R9 interrupt entry");
            do_op(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 step inside handler");
            do_op(8, 1, 0, 0, 0, 0, 0, 0, 0, "R11 return from interrupt");
        end
        do_op(6, 1, 0, 0, 0, 0, 3'd6, 3'd7, 0, "R9 source 6 ignored");
        do_op(6, 1, 0, 0, 0, 0, 3'd7, 3'd7, 0, "R9 source 7 ignored");
        // R10 leaves flags and enable alone
        do_op(4, 1, 0, 0, 0, 4'd3, 0, 3'd5, 0, "R7 short call n3");
        do_op(7, 2, 0, 0, 0, 0, 0, 0, 0, "R10 return keeps flags and ie");
        // R12 set level
        do_op(9, 1, 0, 0, 0, 0, 0, 0, 4'd5, "R12 set level 5");
        do_op(9, 1, 0, 0, 0, 0, 0, 0, 4'd14, "R12 level 14 ignored");
        do_op(9, 1, 0, 0, 0, 0, 0, 0, 4'd15, "R12 level 15 ignored");
        do_op(4, 1, 0, 0, 0, 4'd2, 0, 0, 0, "R12 call from level 5");
        do_op(7, 1, 0, 0, 0, 0, 0, 0, 0, "R12 return to level 5");
        do_op(9, 1, 0, 0, 0, 0, 0, 0, 4'd13, "R12 set level 13");
        // R13 underflow
        do_op(7, 3, 0, 0, 0, 0, 0, 0, 0, "R13 pop on empty");
        do_op(0, 1, 0, 0, 0, 0, 0, 0, 0, "R13 error sticky while stepping");
        do_reset();
        // R14 fill all levels, then R13 overflow
        for (int i = 0; i < DEPTH; i++) begin
            do_op(5, 2, 0, 13'(16 * i + 13'h100), 0, 0, 0, 0, 0, "R14 nested call");
        end
        do_op(5, 2, 0, 13'h0777, 0, 0, 0, 0, 0, "R13 push on full");
        do_op(6, 1, 0, 0, 0, 0, 3'd2, 3'd3, 0, "R13 interrupt on full");
        for (int i = 0; i < DEPTH; i++) begin
            do_op(7, 1, 0, 0, 0, 0, 0, 0, 0, "R14 unwind in reverse order");
        end
        idle("R13 error holds");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule